// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Read Cache

This block is a read-only direct-mapped cache with a second chance. Every line address has a home slot chosen by its index bits. When the home slot does not hold the requested line, the cache looks once more, in the partner slot whose index differs only in the top index bit. A hit in the home slot answers one cycle after the request is taken. A hit in the partner slot answers one cycle later. Only when both slots fail does the cache ask the next memory level for the whole line.

Lines are moved so that the line most recently used ends up in its home slot. After a partner-slot hit the two slots exchange contents. After a refill the new line takes the home slot, and the line that was there moves into the partner slot, which drops whatever the partner slot held. Each response carries a two-bit kind code, so the requester can tell a fast hit, a slow hit and a miss apart. The default geometry is 128 lines of 16 bytes, with 32-bit addresses and 32-bit response words.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: While reset is low and right after it, req_ready is 1 and rsp_valid and mem_req_valid are 0. Reset invalidates every line, so the first access to any address after reset is a miss (kind 3).
- R2: When the home slot (index = addr[10:4]) holds the line, rsp_valid pulses with rsp_kind = 1 (fast) one cycle after the edge that accepted the request.
- R3: When the home slot misses and the partner slot (index XOR 0x40) holds the line, rsp_valid pulses with rsp_kind = 2 (slow) two cycles after the accepting edge.
- R4: When both slots miss, mem_req_valid rises two cycles after the accepting edge with mem_req_addr = addr with bits [3:0] cleared. Both stay steady until the cycle in which mem_rsp_valid is 1. rsp_valid with rsp_kind = 3 follows one cycle after that cycle.
- R5: The stored tag includes address bit 10. A line whose address differs from the request only in bit 10 never counts as a hit for that request.
- R6: After a slow hit the two slots exchange contents. The same line then hits fast, and the line displaced from the home slot hits slow.
- R7: On a refill the new line takes the home slot. The previous home line, if valid, moves to the partner slot and then hits slow. The line that was in the partner slot is lost, so its next access misses.
- R8: On a refill when the home slot is empty, the partner slot keeps its line, and that line still hits.
- R9: req_ready is 1 only while no request is in its second probe or waiting for a refill. Requests presented on consecutive cycles that both hit fast are answered on consecutive cycles.
- R10: rsp_data is the 32-bit word addr[3:2] of the line. Word w occupies bits [32w+31:32w] of mem_rsp_data, with word 0 at the least significant end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_kind | output | 2 | 1 fast hit, 2 slow hit, 3 miss, 0 no response |
| rsp_data | output | 32 | Word read |
| mem_req_valid | output | 1 | Line fetch request to the next level |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_rsp_valid | input | 1 | Refill line present this cycle |
| mem_rsp_data | input | 128 | Refill line, word 0 in the low bits |

## Verification
A fast hit is due one cycle after the accepting edge, and a slow hit two cycles after it. A line fetch request appears two cycles after the accepting edge, and a miss response comes one cycle after the refill cycle. With the bench memory answering on the third cycle of its request, a miss answers five cycles after acceptance. The bench drives and samples on falling edges and counts the falling edges since the accepting rising edge. It compares that count with the latency each kind requires, and it checks the fetch address on the first cycle the request shows. The access sequence is chosen so that every slot exchange, move and eviction is followed by an access whose kind shows where each line now sits.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_FAST = 2'd1,
        RK_SLOW = 2'd2,
        RK_MISS = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE2 = 2'd1,
        ST_REFILL = 2'd2
    } pac_state_e;

endpackage

// File: rtl/pac_line_store.sv
module pac_line_store #(
    parameter int NUM_LINES = 128,
    parameter int TAG_W     = 22,
    parameter int LINE_W    = 128,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic              rd_a_valid,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [LINE_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic              rd_b_valid,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [LINE_W-1:0] rd_b_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic              wa_valid,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [LINE_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [LINE_W-1:0] wb_data
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [LINE_W-1:0]    data_q [NUM_LINES];

    // Valid bits are the only reset state; tag and data are qualified by them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (wa_en) valid_q[wa_idx] <= wa_valid;
            if (wb_en) valid_q[wb_idx] <= wb_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wa_en) begin
            tag_q[wa_idx]  <= wa_tag;
            data_q[wa_idx] <= wa_data;
        end
        if (wb_en) begin
            tag_q[wb_idx]  <= wb_tag;
            data_q[wb_idx] <= wb_data;
        end
    end

    assign rd_a_valid = valid_q[rd_a_idx];
    assign rd_a_tag   = tag_q[rd_a_idx];
    assign rd_a_data  = data_q[rd_a_idx];
    assign rd_b_valid = valid_q[rd_b_idx];
    assign rd_b_tag   = tag_q[rd_b_idx];
    assign rd_b_data  = data_q[rd_b_idx];

endmodule

// File: rtl/pac_probe.sv
module pac_probe #(
    parameter int TAG_W = 22
) (
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit
);

    assign hit = slot_valid && (slot_tag == look_tag);

endmodule

// File: rtl/pac_word_sel.sv
module pac_word_sel #(
    parameter int LINE_W  = 128,
    parameter int WORD_W  = 32,
    localparam int WPL    = LINE_W / WORD_W,
    localparam int WSEL_W = (WPL > 1) ? $clog2(WPL) : 1
) (
    input  logic [LINE_W-1:0] line,
    input  logic [WSEL_W-1:0] sel,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] words [WPL];

    for (genvar w = 0; w < WPL; w++) begin : g_split
        assign words[w] = line[w*WORD_W +: WORD_W];
    end

    assign word = words[sel];

endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache #(
    parameter int ADDR_W     = 32,
    parameter int NUM_LINES  = 128,
    parameter int LINE_BYTES = 16,
    parameter int WORD_W     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_kind,
    output logic [WORD_W-1:0]         rsp_data,
    output logic                      mem_req_valid,
    output logic [ADDR_W-1:0]         mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [LINE_BYTES*8-1:0]   mem_rsp_data
);
    import pac_pkg::*;

    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = $clog2(NUM_LINES);
    localparam int BYTE_W   = $clog2(WORD_W / 8);
    localparam int WPL      = LINE_W / WORD_W;
    localparam int WSEL_W   = (WPL > 1) ? $clog2(WPL) : 1;
    // Stored tag carries the top index bit so a partner-slot resident is distinct.
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W + 1;
    localparam logic [IDX_W-1:0] PAIR_MASK = {1'b1, {(IDX_W-1){1'b0}}};

    typedef struct packed {
        pac_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              rsp_valid;
        rsp_kind_e         rsp_kind;
        logic [WORD_W-1:0] rsp_data;
        logic              mem_req_valid;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    // Line store ports
    logic [IDX_W-1:0]  rd_a_idx, rd_b_idx;
    logic              rd_a_valid, rd_b_valid;
    logic [TAG_W-1:0]  rd_a_tag, rd_b_tag;
    logic [LINE_W-1:0] rd_a_data, rd_b_data;
    logic              wa_en, wa_valid, wb_en, wb_valid;
    logic [IDX_W-1:0]  wa_idx, wb_idx;
    logic [TAG_W-1:0]  wa_tag, wb_tag;
    logic [LINE_W-1:0] wa_data, wb_data;

    // Probe results: [0] home slot, [1] partner slot
    logic              probe_valid [2];
    logic [TAG_W-1:0]  probe_tag   [2];
    logic [TAG_W-1:0]  probe_look  [2];
    logic [1:0]        probe_hit;

    // Word selection from the three line sources
    logic [LINE_W-1:0] sel_line [3];
    logic [WSEL_W-1:0] sel_word [3];
    logic [WORD_W-1:0] sel_out  [3];

    logic              in_idle;
    logic [IDX_W-1:0]  held_idx;
    logic [TAG_W-1:0]  held_tag, req_tag;
    logic              unused_low_bits;

    assign in_idle  = (ctrl_q.state == ST_IDLE);
    assign held_idx = ctrl_q.addr[OFF_W +: IDX_W];
    assign held_tag = ctrl_q.addr[ADDR_W-1 -: TAG_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_low_bits = ^{req_addr[BYTE_W-1:0], ctrl_q.addr[BYTE_W-1:0]};

    // Home slot is read from the live request while idle, else from the held address.
    assign rd_a_idx = in_idle ? req_addr[OFF_W +: IDX_W] : held_idx;
    assign rd_b_idx = held_idx ^ PAIR_MASK;

    pac_line_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .LINE_W    (LINE_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (rd_a_idx),
        .rd_a_valid (rd_a_valid),
        .rd_a_tag   (rd_a_tag),
        .rd_a_data  (rd_a_data),
        .rd_b_idx   (rd_b_idx),
        .rd_b_valid (rd_b_valid),
        .rd_b_tag   (rd_b_tag),
        .rd_b_data  (rd_b_data),
        .wa_en      (wa_en),
        .wa_idx     (wa_idx),
        .wa_valid   (wa_valid),
        .wa_tag     (wa_tag),
        .wa_data    (wa_data),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_data    (wb_data)
    );

    assign probe_valid[0] = rd_a_valid;
    assign probe_tag[0]   = rd_a_tag;
    assign probe_look[0]  = in_idle ? req_tag : held_tag;
    assign probe_valid[1] = rd_b_valid;
    assign probe_tag[1]   = rd_b_tag;
    assign probe_look[1]  = held_tag;

    for (genvar p = 0; p < 2; p++) begin : g_probe
        pac_probe #(.TAG_W(TAG_W)) u_probe (
            .slot_valid (probe_valid[p]),
            .slot_tag   (probe_tag[p]),
            .look_tag   (probe_look[p]),
            .hit        (probe_hit[p])
        );
    end

    // [0] home line for a fast hit, [1] partner line for a slow hit, [2] refill line
    assign sel_line[0] = rd_a_data;
    assign sel_word[0] = req_addr[BYTE_W +: WSEL_W];
    assign sel_line[1] = rd_b_data;
    assign sel_word[1] = ctrl_q.addr[BYTE_W +: WSEL_W];
    assign sel_line[2] = mem_rsp_data;
    assign sel_word[2] = ctrl_q.addr[BYTE_W +: WSEL_W];

    for (genvar s = 0; s < 3; s++) begin : g_wsel
        pac_word_sel #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_wsel (
            .line (sel_line[s]),
            .sel  (sel_word[s]),
            .word (sel_out[s])
        );
    end

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.rsp_valid = 1'b0;
        ctrl_d.rsp_kind  = RK_NONE;
        wa_en    = 1'b0;
        wa_idx   = held_idx;
        wa_valid = 1'b0;
        wa_tag   = held_tag;
        wa_data  = mem_rsp_data;
        wb_en    = 1'b0;
        wb_idx   = held_idx ^ PAIR_MASK;
        wb_valid = 1'b0;
        wb_tag   = rd_a_tag;
        wb_data  = rd_a_data;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (probe_hit[0]) begin
                        ctrl_d.rsp_valid = 1'b1;
                        ctrl_d.rsp_kind  = RK_FAST;
                        ctrl_d.rsp_data  = sel_out[0];
                    end else begin
                        ctrl_d.addr  = req_addr;
                        ctrl_d.state = ST_PROBE2;
                    end
                end
            end
            ST_PROBE2: begin
                if (probe_hit[1]) begin
                    ctrl_d.rsp_valid = 1'b1;
                    ctrl_d.rsp_kind  = RK_SLOW;
                    ctrl_d.rsp_data  = sel_out[1];
                    ctrl_d.state     = ST_IDLE;
                    // Exchange: partner line comes home, home line goes to partner.
                    wa_en    = 1'b1;
                    wa_valid = 1'b1;
                    wa_tag   = rd_b_tag;
                    wa_data  = rd_b_data;
                    wb_en    = 1'b1;
                    wb_valid = rd_a_valid;
                    wb_tag   = rd_a_tag;
                    wb_data  = rd_a_data;
                end else begin
                    ctrl_d.mem_req_valid = 1'b1;
                    ctrl_d.state         = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (mem_rsp_valid) begin
                    ctrl_d.mem_req_valid = 1'b0;
                    ctrl_d.rsp_valid     = 1'b1;
                    ctrl_d.rsp_kind      = RK_MISS;
                    ctrl_d.rsp_data      = sel_out[2];
                    ctrl_d.state         = ST_IDLE;
                    wa_en    = 1'b1;
                    wa_valid = 1'b1;
                    wa_tag   = held_tag;
                    wa_data  = mem_rsp_data;
                    // Displaced home line keeps a second chance only if it was valid.
                    wb_en    = rd_a_valid;
                    wb_valid = 1'b1;
                    wb_tag   = rd_a_tag;
                    wb_data  = rd_a_data;
                end
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.state         <= ST_IDLE;
            ctrl_q.addr          <= '0;
            ctrl_q.rsp_valid     <= 1'b0;
            ctrl_q.rsp_kind      <= RK_NONE;
            ctrl_q.rsp_data      <= '0;
            ctrl_q.mem_req_valid <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready     = in_idle;
    assign rsp_valid     = ctrl_q.rsp_valid;
    assign rsp_kind      = ctrl_q.rsp_kind;
    assign rsp_data      = ctrl_q.rsp_data;
    assign mem_req_valid = ctrl_q.mem_req_valid;
    assign mem_req_addr  = {ctrl_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/pac_cache_chk.sv
module pac_cache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_kind,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid
);
    import pac_pkg::*;

    // R2: a fast response follows an accepting edge by exactly one cycle
    p_fast_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RK_FAST) |-> $past(req_valid && req_ready));

    // R3: a slow response follows an accepting edge by exactly two cycles
    p_slow_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RK_SLOW) |-> $past(req_valid && req_ready, 2));

    // R4: a miss response comes one cycle after the refill cycle
    p_miss_after_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RK_MISS) |-> $past(mem_req_valid && mem_rsp_valid));

    // R4: fetch request and address hold until the refill arrives
    p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: a fetch starts only after a cycle of second probe
    p_fetch_after_probe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> !$past(req_ready));

    // R9: no request is taken while a fetch is outstanding
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R1: every response carries a nonzero kind code
    p_kind_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != RK_NONE));

endmodule

bind pseudo_assoc_cache pac_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_kind      (rsp_kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_pseudo_assoc_cache.sv
`timescale 1ns/1ps
module tb_pseudo_assoc_cache;

    localparam int MEM_LAT = 3;
    localparam int K_FAST = 1, K_SLOW = 2, K_MISS = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         rsp_valid;
    logic [1:0]   rsp_kind;
    logic [31:0]  rsp_data;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pseudo_assoc_cache dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_kind      (rsp_kind),
        .rsp_data      (rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    // Backing memory content: each word derives from its own address.
    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A00_00C3;
    endfunction

    function automatic logic [127:0] line_of(input logic [31:0] a);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of({a[31:4], 4'b0} + 32'(w * 4));
        return l;
    endfunction

    function automatic string req_name(input int id);
        case (id)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One read: checks kind, latency, word, fetch address and hold.
    task automatic access(input logic [31:0] a, input int k, input string rq);
        int cyc;
        int mc;
        int exp_lat;
        cyc = 0;
        mc  = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 40) begin
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                mc++;
                if (mc == 1) begin
                    chk(cyc == 2, "R4", "fetch start cycle", 64'(cyc), 64'd2);
                    chk(mem_req_addr == {a[31:4], 4'b0}, "R4", "fetch address",
                        64'(mem_req_addr), 64'({a[31:4], 4'b0}));
                end
                chk(req_ready == 1'b0, "R9", "ready during fetch", 64'(req_ready), 64'd0);
                if (mc == MEM_LAT) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = line_of(a);
                end
            end
            @(negedge clk);
            cyc++;
        end
        mem_rsp_valid = 1'b0;
        exp_lat = (k == K_FAST) ? 1 : (k == K_SLOW) ? 2 : MEM_LAT + 2;
        chk(rsp_valid == 1'b1, rq, "response present", 64'(rsp_valid), 64'd1);
        chk(rsp_kind == 2'(k), rq, "response kind", 64'(rsp_kind), 64'(k));
        chk(cyc == exp_lat, rq, "response latency", 64'(cyc), 64'(exp_lat));
        chk(rsp_data == word_of(a), "R10", "response word", 64'(rsp_data), 64'(word_of(a)));
        if (k == K_MISS)
            chk(mc == MEM_LAT, "R4", "fetch held until refill", 64'(mc), 64'(MEM_LAT));
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  kind;
        logic [3:0]  req;
    } vec_t;

    // Slot 0x03 (home of 0x1030, 0x5030) pairs with 0x43 (home of 0x1430, 0x9430).
    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1030, 2'd3, 4'd1},  // cold miss
        '{32'h0000_1034, 2'd1, 4'd2},  // home hit, word 1
        '{32'h0000_5030, 2'd3, 4'd4},  // both miss; 1030 moves to 0x43
        '{32'h0000_1038, 2'd2, 4'd3},  // partner hit, then swap
        '{32'h0000_103C, 2'd1, 4'd6},  // swapped line now fast
        '{32'h0000_5034, 2'd2, 4'd6},  // displaced line now slow
        '{32'h0000_1430, 2'd3, 4'd5},  // differs only in bit 10: no hit
        '{32'h0000_1030, 2'd1, 4'd7},  // moved old home line back home? it sits at 0x03
        '{32'h0000_5038, 2'd3, 4'd7},  // evicted partner line misses
        '{32'h0000_1434, 2'd3, 4'd7},  // evicted again
        '{32'h0000_1030, 2'd1, 4'd7},  // displaced home line sits home again
        '{32'h0000_143C, 2'd1, 4'd2},
        '{32'h0000_2450, 2'd3, 4'd8},  // fill slot 0x45
        '{32'h0000_2050, 2'd3, 4'd8},  // home 0x05 empty: 0x45 kept
        '{32'h0000_2454, 2'd1, 4'd8},
        '{32'h0000_2058, 2'd1, 4'd8},
        '{32'h0000_9430, 2'd3, 4'd4},  // 1434 moves to 0x03, 1030 lost
        '{32'h0000_1434, 2'd2, 4'd3},
        '{32'h0000_9438, 2'd2, 4'd6},
        '{32'h0000_1030, 2'd3, 4'd7}   // lost line misses
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "no response in reset", 64'(rsp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1", "no fetch in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            access(VEC[i].addr, int'(VEC[i].kind), req_name(int'(VEC[i].req)));

        // R9: back-to-back fast hits (0x1030 home 0x03, 0x1430 home 0x43)
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'h0000_1030;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready for second request", 64'(req_ready), 64'd1);
        chk(rsp_valid && rsp_kind == 2'(K_FAST), "R9", "first back-to-back kind",
            64'(rsp_kind), 64'(K_FAST));
        chk(rsp_data == word_of(32'h0000_1030), "R9", "first back-to-back word",
            64'(rsp_data), 64'(word_of(32'h0000_1030)));
        req_addr = 32'h0000_1438;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_kind == 2'(K_FAST), "R9", "second back-to-back kind",
            64'(rsp_kind), 64'(K_FAST));
        chk(rsp_data == word_of(32'h0000_1438), "R9", "second back-to-back word",
            64'(rsp_data), 64'(word_of(32'h0000_1438)));

        // R1: reset in mid-run invalidates every line
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1",
            "idle outputs after second reset",
            64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
        rst_n = 1'b1;
        access(32'h0000_1030, K_MISS, "R1");
        access(32'h0000_2454, K_MISS, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule